// File: doc/BRIEF.md
# Indexed Clock Register Port with Event Status

This block is the host-side front end of a real-time clock. A host reaches a byte-wide register space of `DEPTH` locations through two addresses. A write to the even address selects a location. An access to the odd address reads or writes the selected byte. Four locations starting at index 10 are control registers with access rules of their own. Every other location is plain storage.

Control register A holds a 4-bit periodic rate code in bits 3:0 and a 3-bit divider control in bits 6:4. Its bit 7 is an update-in-progress flag that only the time counter moves. Control register B holds the operating mode:

- bit 7: set mode
- bit 6: periodic enable
- bit 5: alarm enable
- bit 4: update-ended enable
- bit 2: binary data mode
- bit 1: 24-hour mode

Control register C collects event flags and clears when it is read. Control register D is a constant status byte.

The external time counter and periodic generator connect through single-cycle pulse inputs and through the mode and rate outputs. The interrupt output stays high from the first enabled event until the host reads register C. The request side takes one request per cycle and has no ready signal, because every request is taken in the cycle it is presented. The response side has no back-pressure. A read answers with `rsp_valid` for exactly one cycle, on the cycle after the request.

Top module: `rtc_regport`

## Requirements
- R1: A write to the even address (`req_addr`=0) stores the low 7 bits of the data as the index. A read of the even address returns 0xFF.
- R2: After reset, register A reads 0x26, register B reads 0x02, register C reads 0x00, register D reads 0x80, and `irq` is low.
- R3: A host write to register A (index 10) updates bits 6:0 and leaves bit 7 at its current value. `rate_code` shows A[3:0] and `divider_ctl` shows A[6:4].
- R4: A host write to register B (index 11) with bit 7 set stores the data with bit 4 forced to 0 and clears A[7].
- R5: Host writes to register C (index 12) and register D (index 13) change nothing.
- R6: A read of register C returns its current value. On the next cycle C is 0x00 and `irq` is low, unless an event arrived in the same cycle.
- R7: Each event sets bits in register C and raises `irq`, but only when its enable in B is set:
  - `evt_periodic` with B[6] sets 0xC0.
  - `evt_alarm` with B[5] sets 0xA0.
  - `evt_update` with B[4] sets 0x90.
  - An event whose enable is clear leaves C and `irq` unchanged.
- R8: A pulse on `uip_begin` sets A[7] when B[7] is 0 and is ignored when B[7] is 1. A pulse on `evt_update` clears A[7].
- R9: `set_mode`, `binary_mode` and `hour24` show B[7], B[2] and B[1].
- R10: Every index outside 10 to 13 is plain read/write storage with no side effects.
- R11: An enabled event in the same cycle as a read of C is kept after the clear, and `irq` stays high.
- R12: A read request gives `rsp_valid` high for exactly one cycle, on the next cycle, with the data in `rsp_rdata`. Writes give no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 1 | 0 = index port, 1 = data port |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the request |
| rsp_rdata | output | 8 | Read data |
| evt_periodic | input | 1 | Periodic event pulse |
| evt_alarm | input | 1 | Alarm match pulse |
| evt_update | input | 1 | Update-ended pulse |
| uip_begin | input | 1 | Update-start pulse from the time counter |
| irq | output | 1 | Level interrupt |
| rate_code | output | 4 | Periodic rate selection |
| divider_ctl | output | 3 | Divider control |
| set_mode | output | 1 | Counter updates frozen |
| binary_mode | output | 1 | Binary rather than BCD data |
| hour24 | output | 1 | 24-hour format |

## Verification
Several rules are checked on every cycle by the assertions:
- the index load
- the one-cycle response timing
- the read-only update flag
- the forced bits of a set-mode write
- the clear of C after a read that meets no event
- the retention of update-ended flags
- the match between `irq` and C[7]

Other behaviour can only be shown by the bench scenarios:
- the full storage pattern
- the sweeps of every byte value through A and B
- the exact flag codes of each event type
- gating by each enable
- the collision of an event with a read of C, where the returned value differs from the value left behind

// File: rtl/rtc_regport_pkg.sv
package rtc_regport_pkg;
  localparam int unsigned CTL_INDEX = 10;

  typedef enum logic [1:0] {
    CTL_A = 2'd0,
    CTL_B = 2'd1,
    CTL_C = 2'd2,
    CTL_D = 2'd3
  } ctl_sel_e;

  localparam logic [7:0] A_RESET = 8'h26;
  localparam logic [7:0] B_RESET = 8'h02;
  localparam logic [7:0] D_VALUE = 8'h80;

  localparam int unsigned A_UIP   = 7;
  localparam int unsigned B_SET   = 7;
  localparam int unsigned B_PEN   = 6;
  localparam int unsigned B_AEN   = 5;
  localparam int unsigned B_UEN   = 4;
  localparam int unsigned B_BIN   = 2;
  localparam int unsigned B_H24   = 1;

  localparam logic [7:0] FLAG_PERIODIC = 8'hC0;
  localparam logic [7:0] FLAG_ALARM    = 8'hA0;
  localparam logic [7:0] FLAG_UPDATE   = 8'h90;
endpackage

// File: rtl/rtc_index_reg.sv
module rtc_index_reg #(
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [IDX_W-1:0] data_i,
  output logic [IDX_W-1:0] idx_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_o <= '0;
    else if (load_i) idx_o <= data_i;
  end

  assert_idx_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> idx_o == $past(data_i));
endmodule

// File: rtl/rtc_store.sv
module rtc_store #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] addr_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o
);
  logic [7:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic [7:0] cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cell_q <= '0;
      else if (wr_en_i && addr_i == IDX_W'(g)) cell_q <= wdata_i;
    end
    assign cells[g] = cell_q;
  end

  assign rdata_o = cells[addr_i];
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
  import rtc_regport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  ctl_sel_e   sel_i,
  input  logic [7:0] wdata_i,
  input  logic       uip_begin_i,
  input  logic       evt_periodic_i,
  input  logic       evt_alarm_i,
  input  logic       evt_update_i,
  output logic [7:0] a_o,
  output logic [7:0] b_o,
  output logic [7:0] c_o,
  output logic [7:0] d_o,
  output logic       irq_o
);
  logic [7:0] a_n, b_n, c_n, flags;
  logic       irq_n, wr_a, wr_b, rd_c;

  assign wr_a = wr_en_i && sel_i == CTL_A;
  assign wr_b = wr_en_i && sel_i == CTL_B;
  assign rd_c = rd_en_i && sel_i == CTL_C;
  assign d_o  = D_VALUE;

  always_comb begin
    flags = '0;
    if (evt_periodic_i && b_o[B_PEN]) flags = flags | FLAG_PERIODIC;
    if (evt_alarm_i    && b_o[B_AEN]) flags = flags | FLAG_ALARM;
    if (evt_update_i   && b_o[B_UEN]) flags = flags | FLAG_UPDATE;

    a_n = a_o;
    if (wr_a) a_n[6:0] = wdata_i[6:0];
    if (wr_b && wdata_i[B_SET])          a_n[A_UIP] = 1'b0;
    else if (evt_update_i)               a_n[A_UIP] = 1'b0;
    else if (uip_begin_i && !b_o[B_SET]) a_n[A_UIP] = 1'b1;

    b_n = b_o;
    if (wr_b) begin
      b_n = wdata_i;
      if (wdata_i[B_SET]) b_n[B_UEN] = 1'b0;
    end

    c_n   = (rd_c ? 8'h00 : c_o) | flags;
    irq_n = (rd_c ? 1'b0 : irq_o) | (|flags);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_o   <= A_RESET;
      b_o   <= B_RESET;
      c_o   <= 8'h00;
      irq_o <= 1'b0;
    end else begin
      a_o   <= a_n;
      b_o   <= b_n;
      c_o   <= c_n;
      irq_o <= irq_n;
    end
  end

  assert_uip_readonly_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a && !uip_begin_i && !evt_update_i) |=> a_o[A_UIP] == $past(a_o[A_UIP]));

  assert_setmode_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_b && wdata_i[B_SET]) |=> (!b_o[B_UEN] && !a_o[A_UIP]));

  assert_status_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && !evt_periodic_i && !evt_alarm_i && !evt_update_i) |=> (c_o == 8'h00 && !irq_o));

  assert_irq_tracks_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == c_o[7]);

  assert_event_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_update_i && b_o[B_UEN]) |=> (c_o[4] && irq_o));
endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
  import rtc_regport_pkg::*;
#(
  parameter int unsigned DEPTH = 128
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic       req_addr,
  input  logic [7:0] req_wdata,
  output logic       rsp_valid,
  output logic [7:0] rsp_rdata,
  input  logic       evt_periodic,
  input  logic       evt_alarm,
  input  logic       evt_update,
  input  logic       uip_begin,
  output logic       irq,
  output logic [3:0] rate_code,
  output logic [2:0] divider_ctl,
  output logic       set_mode,
  output logic       binary_mode,
  output logic       hour24
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam logic [IDX_W-1:0] CTL_LO = IDX_W'(CTL_INDEX);
  localparam logic [IDX_W-1:0] CTL_HI = IDX_W'(CTL_INDEX + 3);

  logic [IDX_W-1:0] idx_q;
  logic             wr_index, wr_data, rd_any, rd_data, ctl_hit;
  ctl_sel_e         sel;
  logic [7:0]       reg_a, reg_b, reg_c, reg_d, store_rd, rd_mux;

  assign wr_index = req_valid &&  req_write && !req_addr;
  assign wr_data  = req_valid &&  req_write &&  req_addr;
  assign rd_any   = req_valid && !req_write;
  assign rd_data  = rd_any && req_addr;
  assign ctl_hit  = (idx_q >= CTL_LO) && (idx_q <= CTL_HI);
  assign sel      = ctl_sel_e'(idx_q[1:0] - CTL_LO[1:0]);

  rtc_index_reg #(.IDX_W(IDX_W)) index_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (wr_index),
    .data_i (req_wdata[IDX_W-1:0]),
    .idx_o  (idx_q)
  );

  rtc_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_data && !ctl_hit),
    .addr_i  (idx_q),
    .wdata_i (req_wdata),
    .rdata_o (store_rd)
  );

  rtc_ctrl_regs ctrl_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en_i        (wr_data && ctl_hit),
    .rd_en_i        (rd_data && ctl_hit),
    .sel_i          (sel),
    .wdata_i        (req_wdata),
    .uip_begin_i    (uip_begin),
    .evt_periodic_i (evt_periodic),
    .evt_alarm_i    (evt_alarm),
    .evt_update_i   (evt_update),
    .a_o            (reg_a),
    .b_o            (reg_b),
    .c_o            (reg_c),
    .d_o            (reg_d),
    .irq_o          (irq)
  );

  always_comb begin
    rd_mux = store_rd;
    if (!req_addr) rd_mux = 8'hFF;
    else if (ctl_hit) begin
      case (sel)
        CTL_A:   rd_mux = reg_a;
        CTL_B:   rd_mux = reg_b;
        CTL_C:   rd_mux = reg_c;
        default: rd_mux = reg_d;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_any;
      if (rd_any) rsp_rdata <= rd_mux;
    end
  end

  assign rate_code   = reg_a[3:0];
  assign divider_ctl = reg_a[6:4];
  assign set_mode    = reg_b[B_SET];
  assign binary_mode = reg_b[B_BIN];
  assign hour24      = reg_b[B_H24];

  assert_rsp_timing_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_any |=> rsp_valid);

  assert_rsp_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_any |=> !rsp_valid);

  assert_even_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_any && !req_addr) |=> rsp_rdata == 8'hFF);
endmodule

// File: tb/rtc_regport_tb_top.sv
module rtc_regport_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0, req_addr = 1'b0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic [7:0] rsp_rdata;
  logic       evt_periodic = 1'b0, evt_alarm = 1'b0, evt_update = 1'b0, uip_begin = 1'b0;
  logic       irq, set_mode, binary_mode, hour24;
  logic [3:0] rate_code;
  logic [2:0] divider_ctl;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rtc_regport #(.DEPTH(128)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .evt_periodic(evt_periodic), .evt_alarm(evt_alarm), .evt_update(evt_update),
    .uip_begin(uip_begin), .irq(irq), .rate_code(rate_code), .divider_ctl(divider_ctl),
    .set_mode(set_mode), .binary_mode(binary_mode), .hour24(hour24)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    d = rsp_rdata;
  endtask

  task automatic rd_idx(input int i, output logic [7:0] d);
    wr(1'b0, 8'(i));
    rd(1'b1, d);
  endtask

  task automatic wr_idx(input int i, input logic [7:0] v);
    wr(1'b0, 8'(i));
    wr(1'b1, v);
  endtask

  task automatic pulse(input bit p, input bit al, input bit up, input bit ub);
    @(negedge clk);
    evt_periodic = p; evt_alarm = al; evt_update = up; uip_begin = ub;
    @(negedge clk);
    evt_periodic = 0; evt_alarm = 0; evt_update = 0; uip_begin = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    logic [7:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 / R9 reset state
    chk("R2 irq", {31'b0, irq}, 0);
    chk("R3 rate_code", {28'b0, rate_code}, 6);
    chk("R3 divider_ctl", {29'b0, divider_ctl}, 2);
    chk("R9 hour24", {31'b0, hour24}, 1);
    chk("R9 binary_mode", {31'b0, binary_mode}, 0);
    chk("R9 set_mode", {31'b0, set_mode}, 0);
    rd_idx(10, d); chk("R2 A", {24'b0, d}, 32'h26);
    rd_idx(11, d); chk("R2 B", {24'b0, d}, 32'h02);
    rd_idx(12, d); chk("R2 C", {24'b0, d}, 32'h00);
    rd_idx(13, d); chk("R2 D", {24'b0, d}, 32'h80);

    // R1 even address
    rd(1'b0, d); chk("R1 even read", {24'b0, d}, 32'hFF);
    wr_idx(8'h94, 8'h5A);
    rd_idx(20, d); chk("R1 index masking", {24'b0, d}, 32'h5A);
    @(negedge clk);
    chk("R12 single pulse", {31'b0, rsp_valid}, 0);

    // R10 storage sweep
    for (int i = 0; i < 128; i++)
      if (i < 10 || i > 13) wr_idx(i, 8'((i * 37 + 11) & 255));
    for (int i = 0; i < 128; i++)
      if (i < 10 || i > 13) begin
        rd_idx(i, d);
        chk("R10 storage", {24'b0, d}, (i * 37 + 11) & 255);
      end

    // R3 sweep of A
    for (int v = 0; v < 256; v++) begin
      wr_idx(10, 8'(v));
      rd(1'b1, d);
      chk("R3 A readback", {24'b0, d}, v & 8'h7F);
      chk("R3 rate_code", {28'b0, rate_code}, v & 15);
      chk("R3 divider_ctl", {29'b0, divider_ctl}, (v >> 4) & 7);
    end
    pulse(0, 0, 0, 1);
    rd_idx(10, d); chk("R8 uip set", {24'b0, d}, 32'hFF);
    wr_idx(10, 8'h00);
    rd(1'b1, d); chk("R3 uip kept on write", {24'b0, d}, 32'h80);
    pulse(0, 0, 1, 0);
    rd(1'b1, d); chk("R8 uip cleared by update", {24'b0, d}, 32'h00);
    rd_idx(12, d); chk("R7 disabled update no flag", {24'b0, d}, 0);
    wr_idx(10, 8'h26);

    // R4 / R9 sweep of B
    for (int v = 0; v < 256; v++) begin
      wr_idx(11, 8'(v));
      rd(1'b1, d);
      e = v[7] ? (8'(v) & 8'hEF) : 8'(v);
      chk("R4 B stored", {24'b0, d}, {24'b0, e});
      chk("R9 set_mode", {31'b0, set_mode}, (v >> 7) & 1);
      chk("R9 binary_mode", {31'b0, binary_mode}, (v >> 2) & 1);
      chk("R9 hour24", {31'b0, hour24}, (v >> 1) & 1);
    end
    wr_idx(11, 8'h02);
    pulse(0, 0, 0, 1);
    wr_idx(11, 8'h92);
    rd_idx(10, d); chk("R4 set mode clears uip", {24'b0, d}, 32'h26);
    pulse(0, 0, 0, 1);
    rd_idx(10, d); chk("R8 uip ignored in set mode", {24'b0, d}, 32'h26);
    rd_idx(11, d); chk("R4 update enable forced low", {24'b0, d}, 32'h82);
    wr_idx(11, 8'h02);

    // R5 read-only C and D
    wr_idx(12, 8'hFF);
    wr_idx(13, 8'h00);
    rd_idx(12, d); chk("R5 C unwritable", {24'b0, d}, 0);
    rd_idx(13, d); chk("R5 D unwritable", {24'b0, d}, 32'h80);
    chk("R5 irq", {31'b0, irq}, 0);

    // R7 / R6 events one at a time
    wr_idx(11, 8'h42); pulse(1, 0, 0, 0);
    chk("R7 periodic irq", {31'b0, irq}, 1);
    rd_idx(12, d); chk("R7 periodic flags", {24'b0, d}, 32'hC0);
    chk("R6 irq dropped", {31'b0, irq}, 0);
    rd(1'b1, d); chk("R6 C cleared", {24'b0, d}, 0);
    wr_idx(11, 8'h22); pulse(0, 1, 0, 0);
    rd_idx(12, d); chk("R7 alarm flags", {24'b0, d}, 32'hA0);
    wr_idx(11, 8'h12); pulse(0, 0, 1, 0);
    rd_idx(12, d); chk("R7 update flags", {24'b0, d}, 32'h90);
    wr_idx(11, 8'h02); pulse(1, 1, 1, 0);
    chk("R7 disabled irq", {31'b0, irq}, 0);
    rd_idx(12, d); chk("R7 disabled flags", {24'b0, d}, 0);
    wr_idx(11, 8'h72); pulse(1, 1, 1, 0);
    rd_idx(12, d); chk("R7 all flags", {24'b0, d}, 32'hF0);

    // R11 event collides with read of C
    pulse(1, 0, 0, 0);
    wr(1'b0, 8'd12);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 1'b1; evt_alarm = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; evt_alarm = 1'b0;
    chk("R11 returned old C", {24'b0, rsp_rdata}, 32'hC0);
    chk("R11 irq kept", {31'b0, irq}, 1);
    rd(1'b1, d); chk("R11 new flags kept", {24'b0, d}, 32'hA0);
    chk("R6 irq after clear", {31'b0, irq}, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule